// File: doc/BRIEF.md
# Command-Buffer SPI Transfer Engine

This block is an SPI master whose transfers are described in memory rather than in registers. Software fills a shared 512-byte buffer with a 16-bit operation header at byte 0, followed by any transmit payload. It then writes a command word that names a timing profile and one of eight slave-select lines. The engine reads the header, streams the payload out one or two bits per SCK period, and writes received bytes back into the same buffer from byte 0 onward. When it finishes it posts a done flag into a write-one-to-clear status register, and a mask register decides whether that flag reaches the interrupt pin.

Bit pacing comes from a separate rate generator through a one-cycle `sck_tick` strobe. Each tick is one SCK half period. Every slave-select pin follows its bit in a global polarity field. During a transfer the selected line is driven at the inverse of that bit. Software can therefore hold any line active or idle by writing the field. Register word indices: 0 global control, 1 raw status, 2 masked status, 3 interrupt mask, 4 command, 8 to 15 profile modes.

Top module: `spi_cmdbuf_engine`

## Requirements
- R1: After reset the engine is idle, every `ss_o` bit is 1, `sck_o` is 0, `irq_o` is 0 and the raw status reads 0.
- R2: Header bits [15:13] are the operation code. Code 2 (write-only) sends `len` bytes starting at buffer byte 2, MSB first on `mosi_o[0]`, with `len` taken from header bits [9:0]. Data changes on the trailing SCK edge and is stable on the leading edge.
- R3: Code 3 (read-only) samples `miso_i[1]` on each leading SCK edge, MSB first, and stores byte k at buffer byte k. The buffer is little-endian in a word, so byte 0 sits at bits [7:0] of word 0.
- R4: Code 1 (read-write) transmits from byte 2 onward and stores received bytes from byte 0 onward in the same transfer.
- R5: With header bit 11 set, a write-only step runs two bits per SCK when the chosen profile's bit 18 is set, and a read-only step does so when bit 16 is set. The higher bit travels on lane 1. `mosi_oe` is 2'b11 for a dual write and 2'b00 for a dual read, and 2'b01 otherwise.
- R6: `ss_o[i]` equals polarity bit i of global control bits [7:0]. While busy, the line chosen by command bits [14:12] is inverted.
- R7: While idle, `sck_o` equals global control bit 17 and `mosi_o[0]` equals bit 18. During a read-only single-lane step `mosi_o[0]` stays at the bit 18 level.
- R8: Raw status bit 0 (done) sets the cycle after the final byte is written back. `irq_o` is the OR of status AND mask, and the masked status register reads status AND mask.
- R9: Writing ones to the raw status register clears those bits.
- R10: A start command (command bits [3:0] = 1) issued while busy sets status bit 4 (invalid control) and leaves the running transfer intact.
- R11: Halt (3) or flush (4) returns the engine to idle with its pointers reset and no done flag. The next transfer starts again at byte 2.
- R12: Codes 0 (sleep) and 4 (set-interrupt) finish with done and toggle no SCK. Codes 5 to 7 set invalid control and start nothing.
- R13: Buffer writes from the register side are ignored while a transfer runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| buf_we | input | 4 | Buffer byte write enables |
| buf_addr | input | 7 | Buffer word address |
| buf_wdata | input | 32 | Buffer write data |
| buf_rdata | output | 32 | Buffer read data, combinational |
| sck_tick | input | 1 | Half-period strobe from the rate generator |
| sck_o | output | 1 | SPI clock |
| ss_o | output | 8 | Slave-select lines |
| mosi_o | output | 2 | Data lanes out |
| mosi_oe | output | 2 | Lane output enables |
| miso_i | input | 2 | Data lanes in |
| irq_o | output | 1 | Interrupt |

## Verification
The scoreboard rebuilds bytes from the lanes at each leading SCK edge. A design that launched data on the wrong edge, sent LSB first, or paired the dual lanes the wrong way round would therefore produce mismatched bytes. The bench issues a second start in the middle of a transfer and writes to the buffer while busy. A design that restarted, or let the write land, would corrupt the data stream or the buffer word it reads back afterwards. A halt is followed by a fresh one-byte transfer, which catches a stale transmit pointer. Sleep and invalid opcodes must leave SCK untouched, and must post done and invalid control respectively.

// File: rtl/spi_cmdbuf_pkg.sv
package spi_cmdbuf_pkg;
    typedef enum logic [2:0] {
        OP_SLEEP  = 3'd0,
        OP_XFER   = 3'd1,
        OP_WR     = 3'd2,
        OP_RD     = 3'd3,
        OP_SETIRQ = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_GO    = 4'd1,
        CMD_TRIG  = 4'd2,
        CMD_HALT  = 4'd3,
        CMD_FLUSH = 4'd4
    } cmd_e;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_FIN} st_e;

    localparam int IRQ_BITS  = 5;
    localparam int IRQ_DONE  = 0;
    localparam int IRQ_INVAL = 4;
    localparam int GC_GATE   = 16;
    localparam int GC_CPOL   = 17;
    localparam int GC_MIDLE  = 18;
    localparam int PM_DRD    = 16;
    localparam int PM_DWR    = 18;
    localparam int HDR_MULTI = 11;
    localparam int CMD_PROF_LSB = 8;
    localparam int CMD_SS_LSB   = 12;

    localparam logic [3:0] RA_GCTRL = 4'd0;
    localparam logic [3:0] RA_STAT  = 4'd1;
    localparam logic [3:0] RA_MSTAT = 4'd2;
    localparam logic [3:0] RA_MASK  = 4'd3;
    localparam logic [3:0] RA_CMD   = 4'd4;
endpackage

// File: rtl/spi_cmdbuf_ram.sv
module spi_cmdbuf_ram #(
    parameter int BYTES = 512,
    localparam int WA = $clog2(BYTES / 4),
    localparam int BA = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic [3:0]    bus_we,
    input  logic [WA-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          sh_we,
    input  logic [BA-1:0] sh_waddr,
    input  logic [7:0]    sh_wdata,
    input  logic [BA-1:0] sh_raddr,
    output logic [7:0]    sh_rdata,
    output logic [15:0]   hdr
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (bus_we[i]) mem[{bus_addr, 2'(i)}] <= bus_wdata[8*i +: 8];
        end
        if (sh_we) mem[sh_waddr] <= sh_wdata;
    end

    always_comb begin
        for (int i = 0; i < 4; i++) bus_rdata[8*i +: 8] = mem[{bus_addr, 2'(i)}];
    end

    assign sh_rdata = mem[sh_raddr];
    assign hdr      = {mem[1], mem[0]};
endmodule

// File: rtl/spi_cmdbuf_irq.sv
module spi_cmdbuf_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic [N-1:0] masked,
    output logic         irq
);
    logic [N-1:0] stat_d, stat_q;

    always_comb stat_d = (stat_q & ~clr) | set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;
    assign masked = stat_q & mask;
    assign irq    = |masked;
endmodule

// File: rtl/spi_cmdbuf_shifter.sv
module spi_cmdbuf_shifter
    import spi_cmdbuf_pkg::*;
#(
    parameter int BYTES = 512,
    localparam int BA = $clog2(BYTES),
    localparam int LW = BA + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          abort,
    input  logic [2:0]    hdr_op,
    input  logic          hdr_multi,
    input  logic [LW-1:0] hdr_len,
    input  logic          dual_rd,
    input  logic          dual_wr,
    input  logic          mosi_idle,
    input  logic [1:0]    miso,
    input  logic [7:0]    rd_data,
    output logic [BA-1:0] rd_addr,
    output logic          mem_we,
    output logic [BA-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          busy,
    output logic          fin,
    output logic          bad_op,
    output logic          phase,
    output logic [1:0]    lanes_o,
    output logic [1:0]    lanes_oe
);
    typedef struct packed {
        st_e           st;
        logic          wr_dir;
        logic          rd_dir;
        logic          dual;
        logic [LW-1:0] left;
        logic [BA-1:0] txp;
        logic [BA-1:0] rxp;
        logic [7:0]    tsh;
        logic [7:0]    rsh;
        logic [2:0]    bits;
        logic          ph;
    } sh_t;

    sh_t  s_d, s_q;
    logic we_d, bad_d;

    always_comb begin
        s_d   = s_q;
        we_d  = 1'b0;
        bad_d = 1'b0;
        unique case (s_q.st)
            ST_IDLE: if (start) begin
                case (hdr_op)
                    OP_XFER, OP_WR, OP_RD: begin
                        s_d.wr_dir = (hdr_op != OP_RD);
                        s_d.rd_dir = (hdr_op != OP_WR);
                        s_d.dual   = hdr_multi && ((hdr_op == OP_RD && dual_rd) ||
                                                   (hdr_op == OP_WR && dual_wr));
                        s_d.left   = hdr_len;
                        s_d.txp    = BA'(2);
                        s_d.rxp    = '0;
                        s_d.bits   = '0;
                        s_d.ph     = 1'b0;
                        s_d.st     = (hdr_len == '0) ? ST_FIN : ST_LOAD;
                    end
                    OP_SLEEP, OP_SETIRQ: s_d.st = ST_FIN;
                    default: bad_d = 1'b1;
                endcase
            end
            ST_LOAD: begin
                s_d.tsh = s_q.wr_dir ? rd_data : 8'hFF;
                s_d.txp = s_q.txp + 1'b1;
                s_d.st  = ST_RUN;
            end
            ST_RUN: if (tick) begin
                if (!s_q.ph) begin
                    s_d.ph  = 1'b1;
                    s_d.rsh = s_q.dual ? {s_q.rsh[5:0], miso} : {s_q.rsh[6:0], miso[1]};
                end else begin
                    s_d.ph = 1'b0;
                    if (s_q.bits == (s_q.dual ? 3'd3 : 3'd7)) begin
                        we_d       = s_q.rd_dir;
                        s_d.rxp    = s_q.rxp + 1'b1;
                        s_d.left   = s_q.left - 1'b1;
                        s_d.bits   = '0;
                        if (s_q.left == LW'(1)) begin
                            s_d.st = ST_FIN;
                        end else begin
                            s_d.tsh = s_q.wr_dir ? rd_data : 8'hFF;
                            s_d.txp = s_q.txp + 1'b1;
                        end
                    end else begin
                        s_d.bits = s_q.bits + 1'b1;
                        s_d.tsh  = s_q.dual ? {s_q.tsh[5:0], 2'b00} : {s_q.tsh[6:0], 1'b0};
                    end
                end
            end
            ST_FIN: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
        if (abort) begin
            s_d.st   = ST_IDLE;
            s_d.ph   = 1'b0;
            s_d.txp  = '0;
            s_d.rxp  = '0;
            s_d.left = '0;
            s_d.bits = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign fin       = (s_q.st == ST_FIN);
    assign bad_op    = bad_d;
    assign phase     = s_q.ph;
    assign rd_addr   = s_q.txp;
    assign mem_we    = we_d;
    assign mem_waddr = s_q.rxp;
    assign mem_wdata = s_q.rsh;

    always_comb begin
        lanes_o  = {1'b0, mosi_idle};
        lanes_oe = 2'b01;
        if (busy && s_q.wr_dir) lanes_o = s_q.dual ? s_q.tsh[7:6] : {1'b0, s_q.tsh[7]};
        if (busy && s_q.dual)   lanes_oe = s_q.wr_dir ? 2'b11 : 2'b00;
    end
endmodule

// File: rtl/spi_cmdbuf_engine.sv
module spi_cmdbuf_engine
    import spi_cmdbuf_pkg::*;
#(
    parameter int              BUF_BYTES  = 512,
    parameter int              NUM_PROF   = 8,
    parameter int              NUM_SS     = 8,
    parameter logic [NUM_SS-1:0] CS_POL_RST = '1,
    localparam int WA     = $clog2(BUF_BYTES / 4),
    localparam int BA     = $clog2(BUF_BYTES),
    localparam int LW     = BA + 1,
    localparam int SS_W   = $clog2(NUM_SS),
    localparam int PROF_W = $clog2(NUM_PROF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        buf_we,
    input  logic [WA-1:0]     buf_addr,
    input  logic [31:0]       buf_wdata,
    output logic [31:0]       buf_rdata,
    input  logic              sck_tick,
    output logic              sck_o,
    output logic [NUM_SS-1:0] ss_o,
    output logic [1:0]        mosi_o,
    output logic [1:0]        mosi_oe,
    input  logic [1:0]        miso_i,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_SS-1:0]   pol;
        logic                gate;
        logic                cpol;
        logic                midle;
        logic [IRQ_BITS-1:0] mask;
        logic [NUM_PROF-1:0] drd;
        logic [NUM_PROF-1:0] dwr;
        logic [SS_W-1:0]     sel;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                busy, fin, bad_op, phase, sh_we;
    logic [BA-1:0]       sh_raddr, sh_waddr;
    logic [7:0]          sh_rdata, sh_wdata;
    logic [15:0]         hdr;
    logic [IRQ_BITS-1:0] st_set, st_clr, status, masked;
    logic                cmd_wr, cmd_go, start_ok, cmd_abort;
    logic [PROF_W-1:0]   cmd_prof;
    logic                unused_bits;

    assign cmd_wr    = reg_we && (reg_addr == RA_CMD);
    assign cmd_go    = cmd_wr && (reg_wdata[3:0] == CMD_GO);
    assign cmd_abort = cmd_wr && (reg_wdata[3:0] == CMD_HALT || reg_wdata[3:0] == CMD_FLUSH);
    assign start_ok  = cmd_go && !busy;
    assign cmd_prof  = reg_wdata[CMD_PROF_LSB +: PROF_W];
    assign unused_bits = ^{reg_wdata, hdr};

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            if (reg_addr == RA_GCTRL) begin
                regs_d.pol   = reg_wdata[NUM_SS-1:0];
                regs_d.gate  = reg_wdata[GC_GATE];
                regs_d.cpol  = reg_wdata[GC_CPOL];
                regs_d.midle = reg_wdata[GC_MIDLE];
            end
            if (reg_addr == RA_MASK) regs_d.mask = reg_wdata[IRQ_BITS-1:0];
            if (reg_addr[3]) begin
                regs_d.drd[reg_addr[PROF_W-1:0]] = reg_wdata[PM_DRD];
                regs_d.dwr[reg_addr[PROF_W-1:0]] = reg_wdata[PM_DWR];
            end
        end
        if (start_ok) regs_d.sel = reg_wdata[CMD_SS_LSB +: SS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{pol: CS_POL_RST, default: '0};
        else        regs_q <= regs_d;
    end

    always_comb begin
        st_set = '0;
        st_set[IRQ_DONE]  = fin;
        st_set[IRQ_INVAL] = (cmd_go && busy) || bad_op;
        st_clr = (reg_we && reg_addr == RA_STAT) ? reg_wdata[IRQ_BITS-1:0] : '0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_GCTRL: begin
                reg_rdata[NUM_SS-1:0] = regs_q.pol;
                reg_rdata[GC_GATE]    = regs_q.gate;
                reg_rdata[GC_CPOL]    = regs_q.cpol;
                reg_rdata[GC_MIDLE]   = regs_q.midle;
            end
            RA_STAT:  reg_rdata[IRQ_BITS-1:0] = status;
            RA_MSTAT: reg_rdata[IRQ_BITS-1:0] = masked;
            RA_MASK:  reg_rdata[IRQ_BITS-1:0] = regs_q.mask;
            default: if (reg_addr[3]) begin
                reg_rdata[PM_DRD] = regs_q.drd[reg_addr[PROF_W-1:0]];
                reg_rdata[PM_DWR] = regs_q.dwr[reg_addr[PROF_W-1:0]];
            end
        endcase
    end

    spi_cmdbuf_ram #(.BYTES(BUF_BYTES)) ram_i (
        .clk       (clk),
        .bus_we    (buf_we & {4{!busy}}),
        .bus_addr  (buf_addr),
        .bus_wdata (buf_wdata),
        .bus_rdata (buf_rdata),
        .sh_we     (sh_we),
        .sh_waddr  (sh_waddr),
        .sh_wdata  (sh_wdata),
        .sh_raddr  (sh_raddr),
        .sh_rdata  (sh_rdata),
        .hdr       (hdr)
    );

    spi_cmdbuf_shifter #(.BYTES(BUF_BYTES)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sck_tick),
        .start     (start_ok),
        .abort     (cmd_abort),
        .hdr_op    (hdr[15:13]),
        .hdr_multi (hdr[HDR_MULTI]),
        .hdr_len   (hdr[LW-1:0]),
        .dual_rd   (regs_q.drd[cmd_prof]),
        .dual_wr   (regs_q.dwr[cmd_prof]),
        .mosi_idle (regs_q.midle),
        .miso      (miso_i),
        .rd_data   (sh_rdata),
        .rd_addr   (sh_raddr),
        .mem_we    (sh_we),
        .mem_waddr (sh_waddr),
        .mem_wdata (sh_wdata),
        .busy      (busy),
        .fin       (fin),
        .bad_op    (bad_op),
        .phase     (phase),
        .lanes_o   (mosi_o),
        .lanes_oe  (mosi_oe)
    );

    spi_cmdbuf_irq #(.N(IRQ_BITS)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (st_set),
        .clr    (st_clr),
        .mask   (regs_q.mask),
        .status (status),
        .masked (masked),
        .irq    (irq_o)
    );

    assign sck_o = regs_q.cpol ^ phase;

    for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
        assign ss_o[g] = regs_q.pol[g] ^ (busy && (regs_q.sel == SS_W'(g)));
    end
endmodule

// File: rtl/spi_cmdbuf_chk.sv
module spi_cmdbuf_chk #(
    parameter int NUM_SS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cpol,
    input logic              midle,
    input logic              sck_o,
    input logic              mosi0,
    input logic [NUM_SS-1:0] ss_o,
    input logic [NUM_SS-1:0] pol,
    input logic              cmd_go,
    input logic              cmd_abort,
    input logic              inval_stat,
    input logic              done_stat
);
    a_r6_ss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ss_o == pol);
    a_r7_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o == cpol);
    a_r7_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mosi0 == midle);
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_stat) |-> $past(busy));
    a_r10_busy_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && busy) |=> inval_stat);
    a_r11_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> !busy);
endmodule

bind spi_cmdbuf_engine spi_cmdbuf_chk #(.NUM_SS(NUM_SS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cpol       (regs_q.cpol),
    .midle      (regs_q.midle),
    .sck_o      (sck_o),
    .mosi0      (mosi_o[0]),
    .ss_o       (ss_o),
    .pol        (regs_q.pol),
    .cmd_go     (cmd_go),
    .cmd_abort  (cmd_abort),
    .inval_stat (status[4]),
    .done_stat  (status[0])
);

// File: tb/spi_cmdbuf_engine_tb_top.sv
module spi_cmdbuf_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  buf_we = '0;
    logic [6:0]  buf_addr = '0;
    logic [31:0] buf_wdata = '0;
    logic [31:0] buf_rdata;
    logic        sck_tick = 1'b0;
    logic        sck_o;
    logic [7:0]  ss_o;
    logic [1:0]  mosi_o, mosi_oe, miso_i;
    logic        irq_o;

    always #10 clk = ~clk;

    spi_cmdbuf_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .sck_tick(sck_tick), .sck_o(sck_o), .ss_o(ss_o), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe), .miso_i(miso_i), .irq_o(irq_o)
    );

    int checks = 0, errors = 0;
    logic [7:0] img [16];
    logic [7:0] exp_q [$];
    logic [7:0] sl_q [$];
    logic [7:0] acc = '0, sl_sh = '0;
    int nb = 0, sl_n = 0, edges = 0;
    logic mon_en = 0, mon_tx = 0, dual_b = 0, cpol_b = 0, sck_prev = 0;
    string cur_req = "R2";

    assign miso_i = dual_b ? sl_sh[7:6] : {sl_sh[7], 1'b0};

    always @(negedge clk) sck_tick <= ~sck_tick;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor and slave model: scoreboard pops expected MOSI bytes on leading edges
    always @(negedge clk) begin
        if (mon_en && sck_o !== sck_prev) begin
            if (sck_o != cpol_b) begin
                edges++;
                if (mon_tx) begin
                    acc = dual_b ? {acc[5:0], mosi_o} : {acc[6:0], mosi_o[0]};
                    nb += dual_b ? 2 : 1;
                    if (nb == 8) begin
                        nb = 0;
                        if (exp_q.size() == 0) chk({cur_req, " extra byte"}, acc, 32'hx);
                        else chk(cur_req, acc, exp_q.pop_front());
                    end
                end
            end else begin
                sl_sh = dual_b ? {sl_sh[5:0], 2'b00} : {sl_sh[6:0], 1'b0};
                sl_n += dual_b ? 2 : 1;
                if (sl_n == 8) begin
                    sl_n = 0;
                    sl_sh = (sl_q.size() != 0) ? sl_q.pop_front() : 8'h00;
                end
            end
        end
        sck_prev = sck_o;
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wr_buf(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); buf_we = 4'hF; buf_addr = a; buf_wdata = d;
        @(negedge clk); buf_we = 4'h0;
    endtask

    task automatic rd_buf(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); buf_addr = a; #1 d = buf_rdata;
    endtask

    task automatic wait_stat(input int b);
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd_reg(4'd1, v);
            if (v[b]) break;
        end
    endtask

    task automatic launch(input logic [2:0] op, input logic multi, input int len,
                          input int prof, input int ss);
        logic [15:0] h;
        h = {op, 1'b0, multi, 11'(len)};
        img[0] = h[7:0];
        img[1] = h[15:8];
        for (int w = 0; w < 4; w++)
            wr_buf(7'(w), {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]});
        acc = '0; nb = 0; sl_n = 0;
        mon_en = 1'b1;
        wr_reg(4'd4, 32'((ss << 12) | (prof << 8) | 1));
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ss", ss_o, 8'hFF);
        chk("R1 sck", sck_o, 0);
        chk("R1 irq", irq_o, 0);
        rd_reg(4'd1, v); chk("R1 status", v, 0);

        // R2 write-only single lane, R6 select, R8 done and irq
        wr_reg(4'd3, 32'h1);
        clear_img(); img[2] = 8'hA5; img[3] = 8'h3C; img[4] = 8'h81;
        exp_q = '{8'hA5, 8'h3C, 8'h81};
        mon_tx = 1; dual_b = 0; cur_req = "R2";
        launch(3'd2, 0, 3, 0, 2);
        repeat (12) @(negedge clk);
        chk("R6 selected line", ss_o, 8'hFB);
        chk("R5 single oe", mosi_oe, 2'b01);
        wait_stat(0);
        mon_en = 0;
        chk("R2 all bytes sent", exp_q.size(), 0);
        @(negedge clk);
        chk("R8 irq", irq_o, 1);
        rd_reg(4'd2, v); chk("R8 masked", v, 32'h1);
        chk("R6 released", ss_o, 8'hFF);

        // R9 write-one-to-clear
        wr_reg(4'd1, 32'h1);
        rd_reg(4'd1, v); chk("R9 cleared", v, 0);
        chk("R9 irq low", irq_o, 0);

        // R7 idle levels, R3 read-only
        wr_reg(4'd0, 32'h0006_00FF);
        cpol_b = 1;
        @(negedge clk);
        chk("R7 sck idle high", sck_o, 1);
        chk("R7 mosi idle", mosi_o[0], 1);
        clear_img(); mon_tx = 0;
        sl_sh = 8'hC3; sl_q = '{8'h5A};
        launch(3'd3, 0, 2, 0, 0);
        repeat (12) @(negedge clk);
        chk("R7 mosi idle during read", mosi_o[0], 1);
        wait_stat(0); mon_en = 0;
        rd_buf(7'd0, v); chk("R3 rx bytes", v[15:0], 16'h5AC3);
        wr_reg(4'd1, 32'h1F);

        // R4 read-write
        wr_reg(4'd0, 32'h0000_00FF); cpol_b = 0;
        @(negedge clk);
        clear_img(); img[2] = 8'h12; img[3] = 8'h34;
        exp_q = '{8'h12, 8'h34}; mon_tx = 1; cur_req = "R4";
        sl_sh = 8'h9E; sl_q = '{8'h01};
        launch(3'd1, 0, 2, 0, 1);
        wait_stat(0); mon_en = 0;
        chk("R4 tx done", exp_q.size(), 0);
        rd_buf(7'd0, v); chk("R4 buffer", v, 32'h3412019E);
        wr_reg(4'd1, 32'h1F);

        // R5 dual write via profile 1
        wr_reg(4'd9, 32'h0004_0000);
        clear_img(); img[2] = 8'hB4; img[3] = 8'hE1;
        exp_q = '{8'hB4, 8'hE1}; dual_b = 1; mon_tx = 1; cur_req = "R5"; edges = 0;
        launch(3'd2, 1, 2, 1, 0);
        repeat (12) @(negedge clk);
        chk("R5 dual write oe", mosi_oe, 2'b11);
        wait_stat(0); mon_en = 0;
        chk("R5 dual bytes", exp_q.size(), 0);
        chk("R5 sck count", edges, 8);
        wr_reg(4'd1, 32'h1F);

        // R5 dual read via profile 2
        wr_reg(4'd10, 32'h0001_0000);
        clear_img(); mon_tx = 0; sl_sh = 8'h6D; sl_q = {};
        launch(3'd3, 1, 1, 2, 0);
        repeat (12) @(negedge clk);
        chk("R5 dual read oe", mosi_oe, 2'b00);
        wait_stat(0); mon_en = 0; dual_b = 0;
        rd_buf(7'd0, v); chk("R5 dual rx", v[7:0], 8'h6D);
        wr_reg(4'd1, 32'h1F);

        // R10 start while busy, R13 buffer write while busy
        clear_img(); img[2] = 8'h01; img[3] = 8'h02; img[4] = 8'h03; img[5] = 8'h04;
        exp_q = '{8'h01, 8'h02, 8'h03, 8'h04}; mon_tx = 1; cur_req = "R10";
        launch(3'd2, 0, 4, 0, 3);
        repeat (20) @(negedge clk);
        wr_reg(4'd4, 32'h1);
        wr_buf(7'd3, 32'hDEADBEEF);
        wait_stat(0); mon_en = 0;
        chk("R10 transfer intact", exp_q.size(), 0);
        rd_reg(4'd1, v); chk("R10 invalid flag", v, 32'h11);
        rd_buf(7'd3, v); chk("R13 write ignored", v, 0);
        wr_reg(4'd1, 32'h1F);

        // R11 halt mid-transfer, then restart from offset 2
        clear_img(); for (int i = 2; i < 10; i++) img[i] = 8'(i);
        mon_tx = 0;
        launch(3'd2, 0, 8, 0, 4);
        repeat (40) @(negedge clk);
        wr_reg(4'd4, 32'h3);
        mon_en = 0;
        chk("R11 select released", ss_o, 8'hFF);
        repeat (300) @(negedge clk);
        rd_reg(4'd1, v); chk("R11 no done", v, 0);
        clear_img(); img[2] = 8'h77; exp_q = '{8'h77}; mon_tx = 1; cur_req = "R11";
        launch(3'd2, 0, 1, 0, 0);
        wait_stat(0); mon_en = 0;
        chk("R11 restart byte", exp_q.size(), 0);
        wr_reg(4'd1, 32'h1F);

        // R12 sleep, set-interrupt, invalid opcode
        clear_img(); mon_tx = 0; edges = 0;
        launch(3'd0, 0, 0, 0, 0);
        wait_stat(0);
        rd_reg(4'd1, v); chk("R12 sleep done", v, 32'h1);
        wr_reg(4'd1, 32'h1F);
        launch(3'd4, 0, 0, 0, 0);
        wait_stat(0);
        rd_reg(4'd1, v); chk("R12 set-irq done", v, 32'h1);
        wr_reg(4'd1, 32'h1F);
        launch(3'd7, 0, 4, 0, 0);
        repeat (40) @(negedge clk);
        mon_en = 0;
        rd_reg(4'd1, v); chk("R12 bad opcode", v, 32'h10);
        chk("R12 no sck", edges, 0);

        // R6 polarity field drives idle lines; R8 mask gates irq
        wr_reg(4'd0, 32'h0000_000F);
        @(negedge clk);
        chk("R6 polarity", ss_o, 8'h0F);
        wr_reg(4'd3, 32'h0);
        chk("R8 masked off", irq_o, 0);
        wr_reg(4'd3, 32'h10);
        @(negedge clk);
        chk("R8 masked on", irq_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule